// File: doc/BRIEF.md
# Modem Line Status Change Detector

This block watches four active-low modem handshake inputs: clear to send, data set ready, ring indicator and carrier detect. It presents their present state and a set of sticky change flags as one 8-bit status byte. Each external input first passes through a synchroniser chain. The synchronised level is then compared with its value one cycle earlier.

Three of the lines flag any change of level. The ring line flags only the moment the ring ends, which is when the pin returns high. A flag stays set until software reads the status byte. The block raises an interrupt request while any flag is set and the modem-status enable is on.

A loopback mode takes the four line states from the modem control outputs instead of the pins. Software can then exercise the whole change logic without external wiring.

Top module: `mdm_stat_detect`

## Requirements
- R1: While reset is high and in the first cycle after it, the flag bits 3:0 of `stat_byte` read 0 and `irq_modem` is low. With the pins high, the whole byte reads 0.
- R2: Outside loopback, `stat_byte[7:4]` show the inverted pin levels: bit 7 carrier detect, bit 6 ring, bit 5 data set ready, bit 4 clear to send. A pin change becomes visible SYNC_STAGES (default 2) clock edges after it is sampled.
- R3: Bit 0 (clear to send), bit 1 (data set ready) and bit 3 (carrier detect) are set one edge after the matching status bit changes in either direction.
- R4: Bit 2 is set one edge after `stat_byte[6]` falls from 1 to 0, which is the ring pin rising. A 0-to-1 change of `stat_byte[6]` sets no flag.
- R5: Flags stay set until a cycle with `stat_read` high. After that edge they read 0, unless a new change arrived at that same edge.
- R6: A change that is detected at the same edge as a read leaves its flag set.
- R7: `irq_modem` is high exactly when `ms_irq_en` is high and at least one of bits 3:0 is set.
- R8: With `mctl[4]` high (loopback), the line states are taken from the control bits: bit 1 gives clear to send, bit 0 gives data set ready, bit 2 gives ring and bit 3 gives carrier detect. The change takes effect in the same cycle, and the external pins have no effect.
- R9: Switching loopback on or off is treated like any other line change. Lines whose value differs between the two sources set their flags under R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_in_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_in_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_in_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_in_n | input | 1 | Carrier detect pin, active low, asynchronous |
| mctl | input | 5 | Modem control: 0 DTR, 1 RTS, 2 aux A, 3 aux B, 4 loopback |
| ms_irq_en | input | 1 | Modem-status interrupt enable |
| stat_read | input | 1 | One-cycle strobe: status byte is being read |
| stat_byte | output | 8 | Line states (7:4) and change flags (3:0) |
| irq_modem | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach from the ports is a read that lands on the same edge as a newly detected change. The pin must be moved exactly two edges before the read strobe, because of the synchroniser delay. The directed part of the bench places the strobe on that edge so that the set-wins rule can be observed.

The random phase then mixes pin changes, reads and loopback entry and exit, with control values that differ from the pins. A reference model tracks the expected byte on every cycle, so collisions, ring edges in both directions and flags caused by loopback switching all occur many times.

// File: rtl/mdm_stat_pkg.sv
`timescale 1ns/1ps
package mdm_stat_pkg;

    localparam int NUM_LINES = 4;

    // line index == change-flag bit position in the status byte
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;

    // modem control bit positions
    localparam int MC_W       = 5;
    localparam int MC_DTR     = 0;
    localparam int MC_RTS     = 1;
    localparam int MC_AUX_A   = 2;
    localparam int MC_AUX_B   = 3;
    localparam int MC_LOOP    = 4;

    // line levels, active high, packed so that bit i == line index i
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lines_t;

    typedef enum logic {
        DET_ANY_CHANGE,
        DET_HIGH_TO_LOW
    } det_kind_e;

    // loopback routing of control outputs onto the line inputs
    function automatic mdm_lines_t loop_route(input logic [MC_W-1:0] mc);
        mdm_lines_t l;
        l.cts = mc[MC_RTS];
        l.dsr = mc[MC_DTR];
        l.ri  = mc[MC_AUX_A];
        l.dcd = mc[MC_AUX_B];
        return l;
    endfunction

    // ring line flags the end of a ring only; the others flag any change
    function automatic det_kind_e kind_of(input int idx);
        return (idx == IDX_RI) ? DET_HIGH_TO_LOW : DET_ANY_CHANGE;
    endfunction

endpackage

// File: rtl/mdm_pin_sync.sv
`timescale 1ns/1ps
module mdm_pin_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/mdm_line_select.sv
`timescale 1ns/1ps
module mdm_line_select
    import mdm_stat_pkg::*;
(
    input  logic [NUM_LINES-1:0] pins_sync_n,
    input  logic [MC_W-1:0]      mctl,
    output mdm_lines_t           lines
);

    always_comb begin
        if (mctl[MC_LOOP]) begin
            lines = loop_route(mctl);
        end else begin
            lines = mdm_lines_t'(~pins_sync_n);
        end
    end

endmodule

// File: rtl/mdm_delta_track.sv
`timescale 1ns/1ps
module mdm_delta_track
    import mdm_stat_pkg::*;
#(
    parameter int N = NUM_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level,
    input  logic         clr,
    output logic [N-1:0] flags
);

    logic [N-1:0] prev_q;
    logic [N-1:0] flag_q;
    logic [N-1:0] event_w;

    for (genvar i = 0; i < N; i++) begin : g_det
        if (kind_of(i) == DET_HIGH_TO_LOW) begin : g_fall
            assign event_w[i] = prev_q[i] & ~level[i];
        end else begin : g_chg
            assign event_w[i] = prev_q[i] ^ level[i];
        end
    end

    // a new event at the read edge wins over the clear
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            flag_q <= '0;
        end else begin
            prev_q <= level;
            flag_q <= event_w | (flag_q & ~{N{clr}});
        end
    end

    assign flags = flag_q;

endmodule

// File: rtl/mdm_stat_detect.sv
`timescale 1ns/1ps
module mdm_stat_detect
    import mdm_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cts_in_n,
    input  logic            dsr_in_n,
    input  logic            ri_in_n,
    input  logic            dcd_in_n,
    input  logic [MC_W-1:0] mctl,
    input  logic            ms_irq_en,
    input  logic            stat_read,
    output logic [7:0]      stat_byte,
    output logic            irq_modem
);

    logic [NUM_LINES-1:0] pins_raw_n;
    logic [NUM_LINES-1:0] pins_sync_n;
    mdm_lines_t           lines;
    logic [NUM_LINES-1:0] flags;

    assign pins_raw_n = {dcd_in_n, ri_in_n, dsr_in_n, cts_in_n};

    mdm_pin_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL('1)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in(pins_raw_n),
        .sync_out(pins_sync_n)
    );

    mdm_line_select u_sel (
        .pins_sync_n(pins_sync_n),
        .mctl       (mctl),
        .lines      (lines)
    );

    mdm_delta_track #(
        .N(NUM_LINES)
    ) u_delta (
        .clk  (clk),
        .rst  (rst),
        .level(lines),
        .clr  (stat_read),
        .flags(flags)
    );

    assign stat_byte = {lines, flags};
    assign irq_modem = ms_irq_en & (|flags);

endmodule

// File: rtl/mdm_stat_detect_chk.sv
`timescale 1ns/1ps
module mdm_stat_detect_chk #(
    parameter int STAGES = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       cts_in_n,
    input logic       dsr_in_n,
    input logic       ri_in_n,
    input logic       dcd_in_n,
    input logic [4:0] mctl,
    input logic       ms_irq_en,
    input logic       stat_read,
    input logic [7:0] stat_byte,
    input logic       irq_modem
);

    // R1
    a_r1_clean_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (stat_byte[3:0] == 4'b0 && !irq_modem));

    // R2
    if (STAGES == 2) begin : g_lvl
        a_r2_pin_levels: assert property (@(posedge clk) disable iff (rst)
            (!mctl[4] && !$past(rst) && !$past(rst, 2)) |->
            stat_byte[7:4] == ~$past({dcd_in_n, ri_in_n, dsr_in_n, cts_in_n}, 2));
    end

    // R3
    a_r3_cts_flag_cause: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $rose(stat_byte[0])) |->
        ($past(stat_byte[4]) != $past(stat_byte[4], 2)));

    a_r3_dcd_flag_cause: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $rose(stat_byte[3])) |->
        ($past(stat_byte[7]) != $past(stat_byte[7], 2)));

    // R4
    a_r4_ring_end_only: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $rose(stat_byte[2])) |->
        ($past(stat_byte[6], 2) && !$past(stat_byte[6])));

    // R5 and R6: after a read a flag survives only through a fresh change
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_read && !$past(rst)) |=>
        (stat_byte[0] == ($past(stat_byte[4]) != $past(stat_byte[4], 2))));

    // R7
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (rst)
        !ms_irq_en |-> !irq_modem);

    a_r7_irq_raised: assert property (@(posedge clk) disable iff (rst)
        (ms_irq_en && stat_byte[3:0] != 4'b0) |-> irq_modem);

    // R8
    a_r8_loop_route: assert property (@(posedge clk) disable iff (rst)
        mctl[4] |-> stat_byte[7:4] == {mctl[3], mctl[2], mctl[0], mctl[1]});

    a_r8_pins_ignored: assert property (@(posedge clk) disable iff (rst)
        (mctl[4] && $past(mctl[4]) && $stable(mctl)) |-> $stable(stat_byte[7:4]));

endmodule

bind mdm_stat_detect mdm_stat_detect_chk #(.STAGES(SYNC_STAGES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cts_in_n (cts_in_n),
    .dsr_in_n (dsr_in_n),
    .ri_in_n  (ri_in_n),
    .dcd_in_n (dcd_in_n),
    .mctl     (mctl),
    .ms_irq_en(ms_irq_en),
    .stat_read(stat_read),
    .stat_byte(stat_byte),
    .irq_modem(irq_modem)
);

// File: tb/mdm_stat_detect_test.sv
`timescale 1ns/1ps
module mdm_stat_detect_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pins_n = 4'hF;   // 0 cts, 1 dsr, 2 ri, 3 dcd
    logic [4:0] mctl = 5'b0;
    logic       ien = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] stat;
    logic       irq;

    int tests = 0;
    int fails = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mdm_stat_detect uut (
        .clk      (clk),
        .rst      (rst),
        .cts_in_n (pins_n[0]),
        .dsr_in_n (pins_n[1]),
        .ri_in_n  (pins_n[2]),
        .dcd_in_n (pins_n[3]),
        .mctl     (mctl),
        .ms_irq_en(ien),
        .stat_read(rd),
        .stat_byte(stat),
        .irq_modem(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit [3:0] m_s1 = 4'hF, m_s2 = 4'hF, m_prev = 4'h0, m_flag = 4'h0;

    function automatic bit [3:0] m_level();
        if (mctl[4]) return {mctl[3], mctl[2], mctl[0], mctl[1]};
        return ~m_s2;
    endfunction

    always @(posedge clk) begin
        bit [3:0] lv;
        bit [3:0] ev;
        if (rst) begin
            m_s1 = 4'hF; m_s2 = 4'hF; m_prev = 4'h0; m_flag = 4'h0;
        end else begin
            lv = m_level();
            ev = m_prev ^ lv;
            ev[2] = m_prev[2] & ~lv[2];
            m_flag = ev | (rd ? 4'h0 : m_flag);
            m_prev = lv;
            m_s2 = m_s1;
            m_s1 = pins_n;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            bit [3:0] lv;
            bit [3:0] fl;
            lv = m_level();
            fl = stat[3:0];
            check(stat[7:4] == lv, mctl[4] ? "R8" : "R2", stat[7:4], lv);
            check({fl[3], fl[1], fl[0]} == {m_flag[3], m_flag[1], m_flag[0]},
                  "R3/R9", fl, m_flag);
            check(fl[2] == m_flag[2], "R4", fl[2], m_flag[2]);
            check(irq == (ien && m_flag != 0), "R7", irq, ien && m_flag != 0);
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_flags();
        rd = 1'b1; step(); rd = 1'b0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        step(); step();
        check(stat == 8'h00, "R1", stat, 0);
        check(irq == 1'b0, "R1", irq, 0);
        rst = 1'b0;
        cmp_on = 1'b1;
        step();
        check(stat == 8'h00, "R1", stat, 0);

        // R2 / R3: assert clear to send
        pins_n[0] = 1'b0;
        step(); step();
        check(stat[4] == 1'b1, "R2", stat[4], 1);
        check(stat[0] == 1'b0, "R3", stat[0], 0);
        step();
        check(stat[0] == 1'b1, "R3", stat[0], 1);
        check(irq == 1'b0, "R7", irq, 0);
        ien = 1'b1; #1;
        check(irq == 1'b1, "R7", irq, 1);

        // R5: sticky, then cleared by read
        repeat (3) step();
        check(stat[0] == 1'b1, "R5", stat[0], 1);
        clear_flags();
        check(stat[3:0] == 4'h0, "R5", stat[3:0], 0);
        check(irq == 1'b0, "R7", irq, 0);

        // R4: ring start sets nothing, ring end sets bit 2
        pins_n[2] = 1'b0;
        repeat (3) step();
        check(stat[6] == 1'b1, "R2", stat[6], 1);
        check(stat[2] == 1'b0, "R4", stat[2], 0);
        pins_n[2] = 1'b1;
        repeat (3) step();
        check(stat[2] == 1'b1, "R4", stat[2], 1);
        clear_flags();

        // R6: change detected on the read edge stays set
        pins_n[3] = 1'b0;
        step(); step();
        rd = 1'b1; step(); rd = 1'b0;
        check(stat[3] == 1'b1, "R6", stat[3], 1);
        clear_flags();
        check(stat[3:0] == 4'h0, "R5", stat[3:0], 0);

        // R8 / R9: loopback
        mctl = 5'b10000; #1;
        check(stat[7:4] == 4'h0, "R8", stat[7:4], 0);
        step();
        check(stat[0] == 1'b1 && stat[3] == 1'b1, "R9", stat[3:0], 4'b1001);
        pins_n = 4'h0;
        repeat (4) step();
        check(stat[7:4] == 4'h0, "R8", stat[7:4], 0);
        mctl = 5'b10110; #1;
        check(stat[7:4] == 4'b0101, "R8", stat[7:4], 4'b0101);
        mctl = 5'b11001; #1;
        check(stat[7:4] == 4'b1010, "R8", stat[7:4], 4'b1010);
        step();
        clear_flags();
        mctl = 5'b00000;
        repeat (4) step();

        // random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 4 == 0) pins_n = 4'($urandom);
            rd = ($urandom % 6 == 0);
            if ($urandom % 16 == 0) ien = ~ien;
            if ($urandom % 12 == 0) begin
                mctl = 5'($urandom);
                if ($urandom % 3 != 0) mctl[4] = 1'b0;
            end
            step();
        end
        rd = 1'b0;
        step();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule